// File: doc/BRIEF.md
# IPv4 Router Packet Classifier

This block sits in front of the forwarding lookup in a router datapath. For each packet it takes the header fields that an upstream parser has already extracted, together with the ingress port. These fields are the destination MAC, an IPv4 ethertype flag, the IP version, the header length, the TTL, a checksum pass flag and the destination IP. From them it picks one of three outcomes: forward in hardware, hand the packet to the CPU, or discard it. Each outcome also carries a reason code. One cycle after the header strobe the block presents the decision with its own valid strobe.

The exception rules are checked in a fixed priority order, and only the first rule that fires is taken and counted. The block holds one MAC address per ingress port and a small table of destination IPs that must be punted to the CPU. These are programmed through a 32-bit register interface, which also reads back a counter per reason, a forwarded-packet counter and a counter of packets injected by the CPU. Register writes take effect at the clock edge. Reads are combinational on the address.

Top module: `rtr_pkt_classifier`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after each cycle in which `hdr_valid` is high, and low otherwise. `dec_action` encodes 0 = forward, 1 = to CPU, 2 = drop.
- R2: When the destination MAC is neither all ones nor the configured MAC of the ingress port, the decision is drop with reason 1.
- R3: Otherwise, a frame whose IPv4 flag is low goes to the CPU with reason 2. ARP and all other non-IP frames fall in this case.
- R4: Otherwise, a header whose checksum flag is low is dropped with reason 3.
- R5: Otherwise, a version other than 4 or a header length other than 5 words sends the packet to the CPU with reason 4.
- R6: Otherwise, a TTL of 0 or 1 sends the packet to the CPU with reason 5.
- R7: Otherwise, a destination IP equal to any non-zero filter-table entry sends the packet to the CPU with reason 6. An entry holding zero never matches, even when the destination IP is zero.
- R8: A packet that passes every rule is forwarded with reason 0.
- R9: Each classified header increments exactly one counter, the one for the first rule that fired, or the forwarded counter. Counters read at address 0x10+i, where i is 0 wrong MAC, 1 non-IP, 2 checksum, 3 version/length, 4 TTL, 5 filter, 6 forwarded.
- R10: Every cycle with `cpu_inject` high increments the counter at 0x17, independently of any header in the same cycle.
- R11: Port p's MAC is written at address 2p (high half) and 2p+1 (low 32 bits). The high register stores only data bits 15:0 and reads back with bits 31:16 as zero.
- R12: The filter table has 8 entries and is reached indirectly. Address 0x08 is a staging register. Writing an index to 0x0A copies the staging register into that entry. Writing an index to 0x09 loads that entry into the staging register. Only data bits 2:0 select the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_port | input | 2 | Ingress port number |
| hdr_dst_mac | input | 48 | Destination MAC address |
| hdr_is_ipv4 | input | 1 | Ethertype is IPv4 |
| hdr_ip_ver | input | 4 | IP version field |
| hdr_ihl | input | 4 | IP header length in 32-bit words |
| hdr_ttl | input | 8 | IP time to live |
| hdr_csum_ok | input | 1 | Header checksum passed |
| hdr_dst_ip | input | 32 | Destination IP address |
| cpu_inject | input | 1 | One packet sent by the CPU this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dec_valid | output | 1 | Decision valid |
| dec_action | output | 2 | Forward, CPU or drop |
| dec_reason | output | 3 | Reason code of the decision |

## Verification
The bench sweeps every combination of ingress port, MAC kind, IPv4 flag, checksum flag, version, header length, four TTL values and four destination IPs. It checks each decision against a priority model. A design that reordered two rules, or let a later rule override an earlier one, would give the wrong reason on the many vectors where several rules fire at once. It would also skew the final counter totals.

One MAC kind differs from the port's own address only in the high half. This catches a comparison that ignores the high register. A MAC taken from the neighbouring port catches a lookup that uses the wrong port. A zero destination IP against empty table entries catches a filter that matches unwritten slots. Index writes with garbage upper bits, and readback through the staging register, catch a table that decodes too many index bits or a read index that does nothing.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   localparam int REG_W  = 32;
   localparam int REG_AW = 5;
   localparam int MAC_W  = 48;
   localparam int IP_W   = 32;
   localparam int N_CNT  = 8;
   localparam int CSEL_W = $clog2(N_CNT);

   typedef enum logic [1:0] {
      ACT_FWD  = 2'd0,
      ACT_CPU  = 2'd1,
      ACT_DROP = 2'd2
   } act_e;

   // reason codes; counter index is reason-1, forward counts in CNT_FWD
   typedef enum logic [2:0] {
      RSN_NONE      = 3'd0,
      RSN_WRONG_DST = 3'd1,
      RSN_NON_IP    = 3'd2,
      RSN_BAD_CSUM  = 3'd3,
      RSN_BAD_HDR   = 3'd4,
      RSN_LOW_TTL   = 3'd5,
      RSN_FILTER    = 3'd6
   } rsn_e;

   localparam int CNT_FWD    = 6;
   localparam int CNT_CPU_TX = 7;

   localparam logic [REG_AW-1:0] A_FLT_DATA   = 5'h08;
   localparam logic [REG_AW-1:0] A_FLT_RD_IDX = 5'h09;
   localparam logic [REG_AW-1:0] A_FLT_WR_IDX = 5'h0A;

   typedef struct packed {
      logic [MAC_W-1:0] dst_mac;
      logic             is_ipv4;
      logic [3:0]       ver;
      logic [3:0]       ihl;
      logic [7:0]       ttl;
      logic             csum_ok;
      logic [IP_W-1:0]  dst_ip;
   } hdr_t;
endpackage

// File: rtl/rpc_cfg_regs.sv
module rpc_cfg_regs
   import rpc_pkg::*;
#(
   parameter int N_PORTS   = 4,
   parameter int FLT_DEPTH = 8,
   localparam int IDX_W    = $clog2(FLT_DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [REG_AW-1:0]            addr,
   input  logic [REG_W-1:0]             wdata,
   output logic [REG_W-1:0]             rdata,
   output logic [N_PORTS*MAC_W-1:0]     mac_flat,
   output logic [FLT_DEPTH*IP_W-1:0]    flt_flat
);
   if (2 * N_PORTS > int'(A_FLT_DATA)) begin : g_bad_ports
      $error("rpc_cfg_regs: port MAC registers overlap the filter registers");
   end
   if ((1 << IDX_W) != FLT_DEPTH || FLT_DEPTH < 2) begin : g_bad_depth
      $error("rpc_cfg_regs: FLT_DEPTH must be a power of two of at least 2");
   end

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [15:0]     hi_q;
      logic [REG_W-1:0] lo_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else if (wr_en) begin
            if (addr == REG_AW'(2 * p))     hi_q <= wdata[15:0];
            if (addr == REG_AW'(2 * p + 1)) lo_q <= wdata;
         end
      end
      assign mac_flat[p*MAC_W +: MAC_W] = {hi_q, lo_q};
   end

   logic [IP_W-1:0]  flt_mem [FLT_DEPTH];
   logic [IP_W-1:0]  stage_q;
   logic [IDX_W-1:0] widx;
   assign widx = wdata[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         for (int i = 0; i < FLT_DEPTH; i++) flt_mem[i] <= '0;
      end else if (wr_en) begin
         if (addr == A_FLT_DATA)        stage_q <= wdata;
         else if (addr == A_FLT_RD_IDX) stage_q <= flt_mem[widx];
         if (addr == A_FLT_WR_IDX)      flt_mem[widx] <= stage_q;
      end
   end

   for (genvar i = 0; i < FLT_DEPTH; i++) begin : g_flt_out
      assign flt_flat[i*IP_W +: IP_W] = flt_mem[i];
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < N_PORTS; p++) begin
         if (addr == REG_AW'(2 * p))     rdata = {16'h0000, mac_flat[p*MAC_W+32 +: 16]};
         if (addr == REG_AW'(2 * p + 1)) rdata = mac_flat[p*MAC_W +: 32];
      end
      if (addr == A_FLT_DATA) rdata = stage_q;
   end
endmodule

// File: rtl/rpc_rules.sv
module rpc_rules
   import rpc_pkg::*;
#(
   parameter int N_PORTS   = 4,
   parameter int FLT_DEPTH = 8,
   localparam int PORT_W   = $clog2(N_PORTS)
) (
   input  logic [PORT_W-1:0]          port,
   input  hdr_t                       hdr,
   input  logic [N_PORTS*MAC_W-1:0]   mac_flat,
   input  logic [FLT_DEPTH*IP_W-1:0]  flt_flat,
   output act_e                       act,
   output rsn_e                       rsn
);
   logic [FLT_DEPTH-1:0] flt_hit;
   logic [MAC_W-1:0]     own_mac;
   logic                 mac_ok;
   logic                 hdr_bad;
   logic                 ttl_low;

   for (genvar i = 0; i < FLT_DEPTH; i++) begin : g_match
      logic [IP_W-1:0] ent;
      assign ent        = flt_flat[i*IP_W +: IP_W];
      assign flt_hit[i] = (ent != '0) && (ent == hdr.dst_ip);
   end

   assign own_mac = mac_flat[port*MAC_W +: MAC_W];
   assign mac_ok  = (hdr.dst_mac == {MAC_W{1'b1}}) || (hdr.dst_mac == own_mac);
   assign hdr_bad = (hdr.ver != 4'd4) || (hdr.ihl != 4'd5);
   assign ttl_low = (hdr.ttl <= 8'd1);

   always_comb begin
      act = ACT_FWD;
      rsn = RSN_NONE;
      if (!mac_ok) begin
         act = ACT_DROP; rsn = RSN_WRONG_DST;
      end else if (!hdr.is_ipv4) begin
         act = ACT_CPU;  rsn = RSN_NON_IP;
      end else if (!hdr.csum_ok) begin
         act = ACT_DROP; rsn = RSN_BAD_CSUM;
      end else if (hdr_bad) begin
         act = ACT_CPU;  rsn = RSN_BAD_HDR;
      end else if (ttl_low) begin
         act = ACT_CPU;  rsn = RSN_LOW_TTL;
      end else if (|flt_hit) begin
         act = ACT_CPU;  rsn = RSN_FILTER;
      end
   end
endmodule

// File: rtl/rpc_stats.sv
module rpc_stats
   import rpc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CNT-1:0]  inc,
   input  logic [CSEL_W-1:0] sel,
   output logic [REG_W-1:0]  rd_val
);
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_w
      $error("rpc_stats: CNT_W must lie between 1 and the register width");
   end

   logic [N_CNT*REG_W-1:0] view;

   for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (inc[i]) q <= q + CNT_W'(1);
      end
      if (CNT_W == REG_W) begin : g_full
         assign view[i*REG_W +: REG_W] = q;
      end else begin : g_ext
         assign view[i*REG_W +: REG_W] = {{(REG_W-CNT_W){1'b0}}, q};
      end
   end

   assign rd_val = view[sel*REG_W +: REG_W];
endmodule

// File: rtl/rtr_pkt_classifier.sv
module rtr_pkt_classifier
   import rpc_pkg::*;
#(
   parameter int N_PORTS   = 4,
   parameter int FLT_DEPTH = 8,
   parameter int CNT_W     = 32,
   localparam int PORT_W   = $clog2(N_PORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [PORT_W-1:0] hdr_port,
   input  logic [47:0]       hdr_dst_mac,
   input  logic              hdr_is_ipv4,
   input  logic [3:0]        hdr_ip_ver,
   input  logic [3:0]        hdr_ihl,
   input  logic [7:0]        hdr_ttl,
   input  logic              hdr_csum_ok,
   input  logic [31:0]       hdr_dst_ip,
   input  logic              cpu_inject,
   input  logic              reg_wr_en,
   input  logic [4:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              dec_valid,
   output logic [1:0]        dec_action,
   output logic [2:0]        dec_reason
);
   if ((1 << PORT_W) != N_PORTS || N_PORTS < 2) begin : g_bad_ports
      $error("rtr_pkt_classifier: N_PORTS must be a power of two of at least 2");
   end

   hdr_t                        hdr_in;
   logic [N_PORTS*MAC_W-1:0]    mac_flat;
   logic [FLT_DEPTH*IP_W-1:0]   flt_flat;
   logic [REG_W-1:0]            cfg_rdata;
   logic [REG_W-1:0]            stat_rdata;
   logic [N_CNT-1:0]            cnt_inc;
   act_e                        act_c, act_q;
   rsn_e                        rsn_c, rsn_q;
   logic                        valid_q;

   always_comb begin
      hdr_in.dst_mac = hdr_dst_mac;
      hdr_in.is_ipv4 = hdr_is_ipv4;
      hdr_in.ver     = hdr_ip_ver;
      hdr_in.ihl     = hdr_ihl;
      hdr_in.ttl     = hdr_ttl;
      hdr_in.csum_ok = hdr_csum_ok;
      hdr_in.dst_ip  = hdr_dst_ip;
   end

   rpc_cfg_regs #(.N_PORTS(N_PORTS), .FLT_DEPTH(FLT_DEPTH)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en && !reg_addr[4]),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (cfg_rdata),
      .mac_flat (mac_flat),
      .flt_flat (flt_flat)
   );

   rpc_rules #(.N_PORTS(N_PORTS), .FLT_DEPTH(FLT_DEPTH)) u_rules (
      .port     (hdr_port),
      .hdr      (hdr_in),
      .mac_flat (mac_flat),
      .flt_flat (flt_flat),
      .act      (act_c),
      .rsn      (rsn_c)
   );

   always_comb begin
      cnt_inc = '0;
      if (hdr_valid) begin
         if (rsn_c == RSN_NONE) cnt_inc[CNT_FWD] = 1'b1;
         else                   cnt_inc[3'(rsn_c) - 3'd1] = 1'b1;
      end
      cnt_inc[CNT_CPU_TX] = cpu_inject;
   end

   rpc_stats #(.CNT_W(CNT_W)) u_stats (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (cnt_inc),
      .sel    (reg_addr[CSEL_W-1:0]),
      .rd_val (stat_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         act_q   <= ACT_FWD;
         rsn_q   <= RSN_NONE;
      end else begin
         valid_q <= hdr_valid;
         if (hdr_valid) begin
            act_q <= act_c;
            rsn_q <= rsn_c;
         end
      end
   end

   assign reg_rdata  = reg_addr[4] ? stat_rdata : cfg_rdata;
   assign dec_valid  = valid_q;
   assign dec_action = act_q;
   assign dec_reason = rsn_q;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
   import rpc_pkg::*;
#(
   parameter int N_PORTS = 4,
   localparam int PORT_W = $clog2(N_PORTS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       hdr_valid,
   input logic [PORT_W-1:0]          hdr_port,
   input logic [47:0]                hdr_dst_mac,
   input logic                       hdr_is_ipv4,
   input logic [3:0]                 hdr_ip_ver,
   input logic [3:0]                 hdr_ihl,
   input logic [7:0]                 hdr_ttl,
   input logic                       hdr_csum_ok,
   input logic [N_PORTS*MAC_W-1:0]   mac_flat,
   input logic [N_CNT-1:0]           cnt_inc,
   input logic                       dec_valid,
   input logic [1:0]                 dec_action,
   input logic [2:0]                 dec_reason
);
   logic mac_ok;
   assign mac_ok = (hdr_dst_mac == '1) ||
                   (hdr_dst_mac == mac_flat[hdr_port*MAC_W +: MAC_W]);

   a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> dec_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !dec_valid);
   a_r2_wrong_dst_drop: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !mac_ok |=> dec_action == 2'd2 && dec_reason == 3'd1);
   a_r4_csum_drop: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && mac_ok && hdr_is_ipv4 && !hdr_csum_ok
      |=> dec_action == 2'd2 && dec_reason == 3'd3);
   a_r6_ttl_punt: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && mac_ok && hdr_is_ipv4 && hdr_csum_ok && hdr_ip_ver == 4'd4 &&
      hdr_ihl == 4'd5 && hdr_ttl <= 8'd1
      |=> dec_action == 2'd1 && dec_reason == 3'd5);
   a_r8_fwd_clean: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_action == 2'd0 |-> dec_reason == 3'd0);
   a_r9_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cnt_inc[N_CNT-2:0]));
   a_r9_counted: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> $countones(cnt_inc[N_CNT-2:0]) == 1);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |-> cnt_inc[N_CNT-2:0] == '0);
endmodule

bind rtr_pkt_classifier rpc_checker #(.N_PORTS(N_PORTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hdr_valid   (hdr_valid),
   .hdr_port    (hdr_port),
   .hdr_dst_mac (hdr_dst_mac),
   .hdr_is_ipv4 (hdr_is_ipv4),
   .hdr_ip_ver  (hdr_ip_ver),
   .hdr_ihl     (hdr_ihl),
   .hdr_ttl     (hdr_ttl),
   .hdr_csum_ok (hdr_csum_ok),
   .mac_flat    (mac_flat),
   .cnt_inc     (cnt_inc),
   .dec_valid   (dec_valid),
   .dec_action  (dec_action),
   .dec_reason  (dec_reason)
);

// File: tb/rtr_pkt_classifier_test.sv
module rtr_pkt_classifier_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [1:0]  hdr_port = '0;
   logic [47:0] hdr_dst_mac = '0;
   logic        hdr_is_ipv4 = 1'b0;
   logic [3:0]  hdr_ip_ver = '0;
   logic [3:0]  hdr_ihl = '0;
   logic [7:0]  hdr_ttl = '0;
   logic        hdr_csum_ok = 1'b0;
   logic [31:0] hdr_dst_ip = '0;
   logic        cpu_inject = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dec_valid;
   logic [1:0]  dec_action;
   logic [2:0]  dec_reason;

   always #4 clk = ~clk;

   rtr_pkt_classifier uut (.*);

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;
   int exp_cnt [8];
   logic [47:0] port_mac [4];
   logic [31:0] flt_ent [8];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic classify(int p, logic [47:0] dmac, logic ip4, logic ck,
                           logic [3:0] ver, logic [3:0] ihl, logic [7:0] ttl,
                           logic [31:0] dip, logic inj);
      logic [1:0] ea;
      logic [2:0] er;
      bit hit;
      string tag;
      hit = 0;
      for (int i = 0; i < 8; i++) if (flt_ent[i] != 0 && flt_ent[i] == dip) hit = 1;
      if (dmac != 48'hFFFF_FFFF_FFFF && dmac != port_mac[p]) begin ea = 2; er = 1; tag = "R2 wrong dst"; end
      else if (!ip4)                 begin ea = 1; er = 2; tag = "R3 non-ip"; end
      else if (!ck)                  begin ea = 2; er = 3; tag = "R4 checksum"; end
      else if (ver != 4 || ihl != 5) begin ea = 1; er = 4; tag = "R5 ver/len"; end
      else if (ttl <= 1)             begin ea = 1; er = 5; tag = "R6 ttl"; end
      else if (hit)                  begin ea = 1; er = 6; tag = "R7 filter"; end
      else                           begin ea = 0; er = 0; tag = "R8 forward"; end
      @(negedge clk);
      hdr_valid = 1'b1; hdr_port = 2'(p); hdr_dst_mac = dmac; hdr_is_ipv4 = ip4;
      hdr_csum_ok = ck; hdr_ip_ver = ver; hdr_ihl = ihl; hdr_ttl = ttl;
      hdr_dst_ip = dip; cpu_inject = inj;
      @(negedge clk);
      hdr_valid = 1'b0; cpu_inject = 1'b0;
      chk("R1 strobe high", 32'(dec_valid), 32'd1);
      chk({tag, " R9 priority"}, {27'd0, dec_action, dec_reason}, {27'd0, ea, er});
      if (er == 0) exp_cnt[6]++; else exp_cnt[er-1]++;
      if (inj) exp_cnt[7]++;
      @(negedge clk);
      chk("R1 strobe low", 32'(dec_valid), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] dips [4];
      logic [47:0] dmac;
      for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
      for (int p = 0; p < 4; p++) port_mac[p] = {16'h02A0 + 16'(p), 32'h1000_0000 + 32'(p * 17)};
      flt_ent = '{32'h0A00_0001, 32'h0, 32'hC0A8_0101, 32'h0, 32'h0, 32'hE000_0005, 32'h0, 32'h0};
      repeat (3) @(negedge clk);
      chk("R1 reset strobe", 32'(dec_valid), 32'd0);
      rd(5'h10, d); chk("R9 reset counter", d, 32'd0);
      rd(5'h00, d); chk("R11 reset mac", d, 32'd0);
      rst_n = 1'b1;

      // R11: port MACs, upper half of high register discarded
      for (int p = 0; p < 4; p++) begin
         wr(5'(2 * p), {16'hDEAD, port_mac[p][47:32]});
         wr(5'(2 * p + 1), port_mac[p][31:0]);
      end
      for (int p = 0; p < 4; p++) begin
         rd(5'(2 * p), d);     chk("R11 mac high", d, {16'h0, port_mac[p][47:32]});
         rd(5'(2 * p + 1), d); chk("R11 mac low", d, port_mac[p][31:0]);
      end

      // R12: indirect filter table
      for (int i = 0; i < 8; i++) if (flt_ent[i] != 0) begin
         wr(5'h08, flt_ent[i]);
         wr(5'h0A, 32'(i));
      end
      wr(5'h08, 32'h1234_5678);
      wr(5'h0A, 32'hFFFF_FFF9);
      flt_ent[1] = 32'h1234_5678;
      wr(5'h08, 32'h0);
      wr(5'h09, 32'd2); rd(5'h08, d); chk("R12 read entry 2", d, 32'hC0A8_0101);
      wr(5'h09, 32'd3); rd(5'h08, d); chk("R12 read empty entry", d, 32'h0);
      wr(5'h09, 32'd1); rd(5'h08, d); chk("R12 index low bits", d, 32'h1234_5678);
      wr(5'h09, 32'd0); rd(5'h08, d); chk("R12 entry 0 kept", d, 32'h0A00_0001);

      dips = '{32'h0A00_0001, 32'hE000_0005, 32'h0A00_00FF, 32'h0};
      for (int p = 0; p < 4; p++)
       for (int mk = 0; mk < 4; mk++)
        for (int ip = 0; ip < 2; ip++)
         for (int ck = 0; ck < 2; ck++)
          for (int vi = 0; vi < 2; vi++)
           for (int hi = 0; hi < 2; hi++)
            for (int ti = 0; ti < 4; ti++)
             for (int di = 0; di < 4; di++) begin
                case (mk)
                   0: dmac = port_mac[p];
                   1: dmac = 48'hFFFF_FFFF_FFFF;
                   2: dmac = port_mac[(p + 1) % 4];
                   default: dmac = port_mac[p] ^ (48'h1 << 40);
                endcase
                classify(p, dmac, 1'(ip), 1'(ck), vi ? 4'd6 : 4'd4, hi ? 4'd6 : 4'd5,
                         (ti == 0) ? 8'd0 : (ti == 1) ? 8'd1 : (ti == 2) ? 8'd2 : 8'd64,
                         dips[di], 1'((p + ti + di) % 5 == 0));
             end

      // R7: zero destination against empty entries, clean header
      classify(0, port_mac[0], 1, 1, 4, 5, 8'd9, 32'h0, 0);
      // R10: inject pulses with no header
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); cpu_inject = 1'b1;
         @(negedge clk); cpu_inject = 1'b0;
         exp_cnt[7]++;
      end

      for (int i = 0; i < 8; i++) begin
         rd(5'(16 + i), d);
         chk(i == 7 ? "R10 injected count" : "R9 reason counter", d, 32'(exp_cnt[i]));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule